// File: doc/BRIEF.md
# SONET Transmit Overhead Error Injector

This block sits on the transmit byte stream of an STS-3/STM-1 signal and corrupts selected overhead bytes so that far-end monitoring can be tested. Every byte arrives with a one-hot position tag that marks the overhead bytes of interest. A flag tells whether the byte belongs to the working signal or to the protection signal. A 13-bit control word chooses which corruptions to arm. An asynchronous trigger input starts one round of injection.

The trigger passes through a synchroniser, and only its rising edge counts. On that edge, each enabled action arms a small state machine with two states, `ARM_IDLE` and `ARM_WAIT`. The transition `ARM_IDLE -> ARM_WAIT` fires on a trigger edge while the action's enable is set. The transition `ARM_WAIT -> ARM_IDLE` fires when the targeted byte passes, and that byte is corrupted in the same cycle. While a machine is in `ARM_WAIT`, it ignores further trigger edges.

Each byte leaves through one register stage. Its value is unchanged unless an armed action consumes it. Computing the parity bytes and building the frame are done elsewhere.

Top module: `ohd_err_injector`

## Requirements
- R1: Only a rising edge of `trig_in`, after a two-flop synchroniser, arms actions. Holding `trig_in` high arms each action once. Up to three bytes presented from the cycle in which `trig_in` first goes high may still pass unarmed. From the fourth byte onward, the armed state is in force.
- R2: With `ctrl[0]` set at the edge, the next working byte tagged `in_tag[0]` (B1) leaves with all bits inverted. Later B1 bytes pass unchanged.
- R3: With `ctrl[n]` set (n = 1..3), the next working byte tagged `in_tag[n]` (B2 of STS-1 number n) leaves inverted, once.
- R4: With `ctrl[4+n]` set (n = 1..3), the next working byte tagged `in_tag[4+n]` (B3 of port n) leaves inverted, once. While `au4_mode` is high at the edge, only port 1 (`ctrl[5]`) is honoured.
- R5: With `ctrl[7+n]` set (n = 1..3), the next working byte tagged `in_tag[7+n]` (G1 of port n) leaves with its upper nibble forced to 4'b0001 and its lower nibble unchanged, once. While `au4_mode` is high at the edge, only port 1 (`ctrl[8]`) is honoured.
- R6: With `ctrl[4]` set, the next working byte tagged `in_tag[4]` (M1) leaves as 8'h01, once.
- R7: `ctrl[11]` inverts the next protection byte (`in_prot`=1) tagged `in_tag[1]`. `ctrl[12]` forces the next protection byte tagged `in_tag[4]` to 8'h01. Working actions never touch protection bytes, and protection actions never touch working bytes.
- R8: A byte with no consuming action appears on `out_data` one clock later, unchanged.
- R9: A trigger edge that reaches an action while that action is still armed is ignored. This includes an edge in the same cycle as the consuming byte. Each selected byte is therefore corrupted at most once per arming.
- R10: During and after reset, `out_data` is 0 and no action is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous injection trigger |
| ctrl | input | 13 | Action enables, bit layout as in R2 to R7 |
| au4_mode | input | 1 | Concatenated mode; masks ports 2 and 3 for B3 and G1 |
| in_data | input | 8 | Incoming byte |
| in_tag | input | 11 | One-hot overhead position tag, 0 for other bytes |
| in_prot | input | 1 | Byte belongs to the protection signal |
| out_data | output | 8 | Outgoing byte, one cycle later |

## Verification
A trigger edge and the consumption of an armed byte can fall in the same cycle. In that cycle the state machine leaves `ARM_WAIT` while an arm request is present. The bench arms B1, then raises the trigger so that its synchronised edge lands exactly on the cycle in which a B1 byte passes. That byte must be inverted. The B1 byte sent after it must pass unchanged, which shows that the edge was dropped and not queued. Random rounds also re-trigger while actions are still armed and compare every byte against a model of the armed flags.

// File: rtl/ohd_inj_pkg.sv
package ohd_inj_pkg;

    localparam int NUM_ACT = 13;
    localparam int TAG_W   = 11;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_t;

    // Actions whose byte is inverted: B1, B2 x3, B3 x3, protection B2
    localparam logic [NUM_ACT-1:0] INV_MASK = 13'b0_1000_1110_1111;
    // Actions forcing the M1 count to one: working and protection line REI
    localparam logic [NUM_ACT-1:0] M1_MASK  = 13'b1_0000_0001_0000;
    // Actions forcing a path REI into G1
    localparam logic [NUM_ACT-1:0] G1_MASK  = 13'b0_0111_0000_0000;

    // Tag bit watched by an action
    function automatic int slot_tag(input int s);
        if (s == 11) return 1;
        if (s == 12) return 4;
        return s;
    endfunction

    // Action acts on the protection signal
    function automatic bit slot_prot(input int s);
        return (s >= 11);
    endfunction

    // Action belongs to port 2 or 3 of B3 / G1 (masked in AU-4 mode)
    function automatic bit slot_upper_port(input int s);
        return (s == 6) || (s == 7) || (s == 9) || (s == 10);
    endfunction

endpackage

// File: rtl/ohd_trig_edge.sv
module ohd_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic edge_o
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], trig_async};
        end
    end

    assign edge_o = chain[SYNC_STAGES-1] && !chain[SYNC_STAGES];

    // R1: a held level yields a single-cycle edge
    a_r1_one_cycle_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/ohd_arm_slot.sv
module ohd_arm_slot
    import ohd_inj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_edge,
    input  logic enable,
    input  logic tag_hit,
    output logic pending,
    output logic consume
);
    arm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (arm_edge && enable) state_d = ARM_WAIT;
            ARM_WAIT: if (tag_hit)            state_d = ARM_IDLE;
            default:                          state_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == ARM_WAIT);
        consume = (state_q == ARM_WAIT) && tag_hit;
    end

    // R1: arming only follows an enabled trigger edge
    a_r1_arm_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(arm_edge && enable));

    // R9: armed state persists until its byte passes, edges notwithstanding
    a_r9_hold_until_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tag_hit) |=> pending);

    // R9: the consuming byte always disarms, even with a coincident edge
    a_r9_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tag_hit) |=> !pending);

endmodule

// File: rtl/ohd_err_injector.sv
module ohd_err_injector
    import ohd_inj_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_in,
    input  logic [NUM_ACT-1:0]   ctrl,
    input  logic                 au4_mode,
    input  logic [DATA_W-1:0]    in_data,
    input  logic [TAG_W-1:0]     in_tag,
    input  logic                 in_prot,
    output logic [DATA_W-1:0]    out_data
);
    localparam int NIB = 4;
    localparam logic [DATA_W-1:0] M1_ONE  = DATA_W'(1);
    localparam logic [NIB-1:0]    REI_ONE = NIB'(1);

    logic               trig_edge;
    logic [NUM_ACT-1:0] match;
    logic [NUM_ACT-1:0] eff_en;
    logic [NUM_ACT-1:0] pend;
    logic [NUM_ACT-1:0] hit;
    logic [DATA_W-1:0]  data_d;

    ohd_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .edge_o     (trig_edge)
    );

    for (genvar s = 0; s < NUM_ACT; s++) begin : g_slot
        localparam int TI = slot_tag(s);
        localparam bit PR = slot_prot(s);
        localparam bit UP = slot_upper_port(s);

        assign match[s]  = in_tag[TI] && (in_prot == PR);
        assign eff_en[s] = ctrl[s] && !(UP && au4_mode);

        ohd_arm_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_edge (trig_edge),
            .enable   (eff_en[s]),
            .tag_hit  (match[s]),
            .pending  (pend[s]),
            .consume  (hit[s])
        );
    end

    always_comb begin
        data_d = in_data;
        if (|(hit & INV_MASK)) begin
            data_d = ~in_data;
        end else if (|(hit & M1_MASK)) begin
            data_d = M1_ONE;
        end else if (|(hit & G1_MASK)) begin
            data_d = {REI_ONE, in_data[DATA_W-NIB-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else begin
            out_data <= data_d;
        end
    end

    // R8: untagged bytes pass one cycle later, unchanged
    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tag == '0) |=> (out_data == $past(in_data)));

    // R6: an armed working line REI forces the M1 count to one
    a_r6_m1_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tag[4] && !in_prot && pend[4]) |=> (out_data == M1_ONE));

    // R4: port 3 B3 never arms while AU-4 mode is set
    a_r4_au4_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[7]) |-> !$past(au4_mode));

    // R7: protection actions leave working bytes alone
    a_r7_prot_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_prot |-> !hit[11] && !hit[12]);

endmodule

// File: tb/ohd_err_injector_tb.sv
module ohd_err_injector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [12:0] ctrl = '0;
    logic        au4_mode = 1'b0;
    logic [7:0]  in_data = '0;
    logic [10:0] in_tag = '0;
    logic        in_prot = 1'b0;
    logic [7:0]  out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit pend [13];

    always #4 clk = ~clk;   // 125 MHz

    ohd_err_injector u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ctrl(ctrl),
        .au4_mode(au4_mode), .in_data(in_data), .in_tag(in_tag),
        .in_prot(in_prot), .out_data(out_data)
    );

    function automatic string req_of(input int t, input bit p);
        if (t >= 11) return "R8";
        if (p && (t == 1 || t == 4)) return "R7";
        if (t == 0) return "R2";
        if (t <= 3) return "R3";
        if (t == 4) return "R6";
        if (t <= 7) return "R4";
        return "R5";
    endfunction

    function automatic int stag(input int s);
        return (s == 11) ? 1 : (s == 12) ? 4 : s;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: out_data=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected byte from model state; consumes matching armed actions
    task automatic model(input logic [7:0] d, input int t, input bit p, output logic [7:0] e);
        e = d;
        for (int s = 0; s < 13; s++) begin
            if (t < 11 && pend[s] && stag(s) == t && ((s >= 11) == p)) begin
                pend[s] = 1'b0;
                if (t == 4)      e = 8'h01;
                else if (t >= 8) e = {4'b0001, d[3:0]};
                else             e = ~d;
            end
        end
    endtask

    // Called just after a negedge; drives, waits a clock, samples at negedge
    task automatic send(input logic [7:0] d, input int t, input bit p, input string tagreq);
        logic [7:0] e;
        model(d, t, p, e);
        in_data = d;
        in_tag  = (t < 11) ? (11'b1 << t) : '0;
        in_prot = p;
        @(posedge clk);
        @(negedge clk);
        check((tagreq.len() != 0) ? tagreq : req_of(t, p), out_data, e);
    endtask

    task automatic model_arm(input logic [12:0] c, input bit a);
        for (int s = 0; s < 13; s++) begin
            if (c[s] && !(a && (s == 6 || s == 7 || s == 9 || s == 10)))
                pend[s] = 1'b1;
        end
    endtask

    // Full trigger pulse: rise, settle, arm, fall, settle
    task automatic fire(input logic [12:0] c, input bit a);
        ctrl = c;
        au4_mode = a;
        trig_in = 1'b1;
        for (int i = 0; i < 4; i++) send(8'($urandom), 11, 1'b0, "R1");
        model_arm(c, a);
        trig_in = 1'b0;
        for (int i = 0; i < 3; i++) send(8'($urandom), 11, 1'b0, "R8");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9157));
        for (int s = 0; s < 13; s++) pend[s] = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", out_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", out_data, 8'h00);
        // R10: nothing armed after reset, every tag passes
        for (int t = 0; t < 11; t++) send(8'h5A + 8'(t), t, 1'b0, "R10");

        // R2: single B1 inversion
        fire(13'h0001, 1'b0);
        send(8'h3C, 0, 1'b0, "R2");
        send(8'h3C, 0, 1'b0, "R2");

        // R7: protection vs working isolation
        fire(13'h1802, 1'b0);
        send(8'h11, 1, 1'b1, "R7");
        send(8'h22, 4, 1'b0, "R7");
        send(8'h33, 4, 1'b1, "R7");
        send(8'h44, 1, 1'b0, "R3");
        send(8'h55, 1, 1'b0, "R3");

        // R4/R5: AU-4 masking of ports 2 and 3
        fire(13'h07E0, 1'b1);
        for (int t = 5; t < 11; t++) send(8'hC7, t, 1'b0, "");

        // R1: held trigger arms once
        ctrl = 13'h0001;
        au4_mode = 1'b0;
        trig_in = 1'b1;
        for (int i = 0; i < 4; i++) send(8'h00, 11, 1'b0, "R1");
        model_arm(13'h0001, 1'b0);
        for (int i = 0; i < 8; i++) send(8'hF0, 0, 1'b0, "R1");
        trig_in = 1'b0;
        for (int i = 0; i < 3; i++) send(8'h00, 11, 1'b0, "R8");

        // R9: trigger edge coincides with the consuming B1 byte
        fire(13'h0001, 1'b0);
        trig_in = 1'b1;
        send(8'h01, 11, 1'b0, "R9");
        send(8'h02, 11, 1'b0, "R9");
        send(8'hA5, 0, 1'b0, "R9");   // consumed in the edge cycle
        for (int i = 0; i < 3; i++) send(8'h00, 11, 1'b0, "R9");
        trig_in = 1'b0;
        for (int i = 0; i < 3; i++) send(8'h00, 11, 1'b0, "R9");
        send(8'hA5, 0, 1'b0, "R9");   // edge was dropped: clean

        // Random rounds, including re-triggers while still armed
        for (int r = 0; r < 60; r++) begin
            fire(13'($urandom), 1'($urandom));
            for (int b = 0; b < 14; b++)
                send(8'($urandom), int'($urandom_range(0, 11)), 1'($urandom), "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule